// File: doc/BRIEF.md
# I2C Multi-Master Bus Controller

This block is a bus master for an I2C bus that other masters may share. A host drives it with one discrete command at a time: produce a START, produce a repeated START, send one byte (an address or data byte, launched by writing the transmit buffer), clock in one byte, send the acknowledge bit that follows a received byte, or produce a STOP. Each command runs to completion, reports a one-cycle done pulse, and leaves the bus in a defined state. After a START or a byte, SCL is held low. After a STOP, both lines are released.

The open-drain lines are modelled as an output-enable per line (`1` pulls the wire low) plus a raw input per line. Both inputs pass through two-flop synchronizers. From the synchronized lines the block tracks START and STOP conditions made by any master, so the host can tell when the bus is free. Whenever the block has released SDA, it compares the line against its own output. If it reads low, the block has lost arbitration: it lets go of both lines, abandons the command and flags a bus collision. Commands are never queued. A command or buffer write that arrives while one is running is dropped and flagged as a write collision.

SCL timing comes from a run-time half-period count. Every high phase is timed only once SCL actually reads high, so a device that holds SCL low simply lengthens the bit.

Top module: `i2c_mm_master`

## Requirements
- R1: A command is accepted only while the block is idle. `cmd_op` encodes the commands: 0 START, 1 repeated START, 2 STOP, 3 receive byte, 4 send acknowledge. A one-cycle `wr_buf` launches a byte transmit. Any other `cmd_op` value has no effect. `busy` is high while a command runs, and `done` pulses for one cycle, with `busy` falling, when the command completes.
- R2: If `cmd_valid` or `wr_buf` is asserted while a command is running, it is discarded and no new bus activity starts. The same applies when both are asserted together. In both cases the sticky `wcol` flag is set. `clr_flags` clears it.
- R3: A falling SDA edge while SCL is high sets `start_seen` and clears `stop_seen`. A rising SDA edge while SCL is high sets `stop_seen` and clears `start_seen`. The two flags are never high together.
- R4: `start_seen` and `stop_seen` are low after reset and at all times while `en` is low. While `en` is low, both line enables are also released.
- R5: `bus_free` is high when `stop_seen` is high, or when both flags are low. Otherwise it is low.
- R6: If `irq_en` is high and a STOP is detected while `start_seen` is high, the sticky `irq` is set. `irq` is also set, when `irq_en` is high, on every `done` and on arbitration loss.
- R7: Arbitration loss means SDA reads low while the block releases it. It is detected during the START condition, during the repeated START, on the eight data bits of a transmit, and on the acknowledge bit. On loss the block sets sticky `bcol`, releases SDA and SCL, returns to idle and gives no `done`.
- R8: A transmit sends the eight buffer bits MSB first and then releases SDA for a ninth bit. The level sampled on that ninth bit goes to `ack_rcvd` (0 = acknowledged). SDA changes only while SCL is low.
- R9: A receive keeps SDA released for eight SCL pulses and places the bits sampled on SCL high into `rx_data`, MSB first.
- R10: The acknowledge command clocks one bit. When `ack_val` is 0 it pulls SDA low for that bit, and when `ack_val` is 1 it leaves SDA released.
- R11: START ends with SDA and SCL both pulled low. A repeated START releases SDA, then SCL, then pulls SDA and SCL low in turn. STOP ends with both lines released.
- R12: Each SCL high phase lasts `half_div`+1 cycles, counted only after synchronized SCL reads high. While SCL is held low externally, the command stays busy. `half_div` must be at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Module enable; low clears flags and releases lines |
| irq_en | input | 1 | Enables setting of `irq` |
| clr_flags | input | 1 | Clears `wcol`, `bcol` and `irq` |
| half_div | input | DIV_W | SCL half-period length minus one, in clocks |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R1) |
| ack_val | input | 1 | Bit sent by the acknowledge command |
| wr_buf | input | 1 | Transmit buffer write strobe; starts a byte transmit |
| wr_data | input | 8 | Byte written to the transmit buffer |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Sticky interrupt |
| rx_data | output | 8 | Last received byte |
| ack_rcvd | output | 1 | Acknowledge bit sampled after the last transmit |
| start_seen | output | 1 | START seen on the bus since the last STOP |
| stop_seen | output | 1 | STOP seen on the bus since the last START |
| bus_free | output | 1 | Bus may be taken |
| wcol | output | 1 | Sticky write-collision flag |
| bcol | output | 1 | Sticky bus-collision (arbitration loss) flag |

## Verification
Some properties are checked on every cycle:
- the START-seen and STOP-seen flags never coincide, and both stay clear while the block is disabled;
- a command or write that lands on a running command always produces a write collision;
- an arbitration loss always leaves both lines released with the block idle;
- SDA never moves during a byte while the block has SCL released;
- a done pulse always ends a busy period.

The bench scenarios cover the rest:
- the bit order on the wire, the sampled acknowledge and the received byte;
- arbitration loss in each of the four phases;
- the wait on a held-low SCL;
- the interrupt on a STOP from another master;
- the rule that discarded writes start nothing.

// File: rtl/i2c_mm_master.sv
module i2c_mm_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             irq_en,
  input  logic             clr_flags,
  input  logic [DIV_W-1:0] half_div,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic             ack_val,
  input  logic             wr_buf,
  input  logic [7:0]       wr_data,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy,
  output logic             done,
  output logic             irq,
  output logic [7:0]       rx_data,
  output logic             ack_rcvd,
  output logic             start_seen,
  output logic             stop_seen,
  output logic             bus_free,
  output logic             wcol,
  output logic             bcol
);
  typedef enum logic [2:0] {IDLE, GEN_S, GEN_RS, GEN_P, XFER} st_t;
  typedef enum logic [1:0] {M_TX, M_RX, M_ACK} mode_t;

  st_t              st;
  mode_t            mode;
  logic [1:0]       ph;
  logic [3:0]       bitn;
  logic [8:0]       sh;
  logic [DIV_W-1:0] cnt;
  logic [1:0]       scl_q, sda_q;
  logic             scl_d, sda_d;

  wire scl_s = scl_q[1];
  wire sda_s = sda_q[1];
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  wire hi_ph = (st == GEN_S && ph <= 2'd1) || (st == GEN_RS && (ph == 2'd1 || ph == 2'd2)) ||
               (st == GEN_P && ph >= 2'd1) || (st == XFER && ph == 2'd1);
  wire run  = ~hi_ph | scl_s;
  wire tick = (st != IDLE) && run && (cnt == half_div);
  wire [3:0] last_bit = (mode == M_TX) ? 4'd8 : (mode == M_RX) ? 4'd7 : 4'd0;
  wire chk_bit = (mode == M_TX && bitn < 4'd8) || mode == M_ACK;

  wire lose = (st == GEN_S && ph == 2'd0 && tick && !sda_s) ||
              (st == GEN_RS && ph == 2'd1 && tick && !sda_s) ||
              (st == XFER && ph == 2'd1 && scl_s && !sda_oe && !sda_s && chk_bit);
  wire fin  = tick && ((st == GEN_S && ph == 2'd2) || (st == GEN_RS && ph == 2'd3) ||
                       (st == GEN_P && ph == 2'd2) || (st == XFER && ph == 2'd1 && bitn == last_bit));

  wire idle    = (st == IDLE);
  wire cmd_go  = cmd_valid & ~wr_buf & idle;
  wire wr_go   = wr_buf & ~cmd_valid & idle;
  wire collide = (cmd_valid | wr_buf) & (~idle | (cmd_valid & wr_buf));

  assign busy     = ~idle;
  assign bus_free = stop_seen | ~start_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11; sda_q <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i}; sda_q <= {sda_q[0], sda_i};
      scl_d <= scl_s; sda_d <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; mode <= M_TX; ph <= 2'd0; bitn <= 4'd0; sh <= '1; cnt <= '0;
      scl_oe <= 1'b0; sda_oe <= 1'b0; done <= 1'b0; irq <= 1'b0;
      rx_data <= 8'h00; ack_rcvd <= 1'b1;
      start_seen <= 1'b0; stop_seen <= 1'b0; wcol <= 1'b0; bcol <= 1'b0;
    end else if (!en) begin
      st <= IDLE; ph <= 2'd0; cnt <= '0; scl_oe <= 1'b0; sda_oe <= 1'b0; done <= 1'b0;
      irq <= 1'b0; start_seen <= 1'b0; stop_seen <= 1'b0; wcol <= 1'b0; bcol <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clr_flags) begin wcol <= 1'b0; bcol <= 1'b0; irq <= 1'b0; end
      if (start_det) begin start_seen <= 1'b1; stop_seen <= 1'b0; end
      if (stop_det) begin
        stop_seen <= 1'b1; start_seen <= 1'b0;
        if (irq_en && start_seen) irq <= 1'b1;
      end
      if (collide) wcol <= 1'b1;

      if (idle || tick) cnt <= '0;
      else if (run)     cnt <= cnt + 1'b1;

      if (lose) begin
        st <= IDLE; scl_oe <= 1'b0; sda_oe <= 1'b0; bcol <= 1'b1;
        if (irq_en) irq <= 1'b1;
      end else if (fin) begin
        st <= IDLE; done <= 1'b1;
        if (irq_en) irq <= 1'b1;
        if (st == GEN_P) sda_oe <= 1'b0;
        else scl_oe <= 1'b1;
        if (st == XFER && mode == M_TX) ack_rcvd <= sda_s;
        if (st == XFER && mode == M_RX) rx_data <= {sh[6:0], sda_s};
      end else begin
        case (st)
          IDLE: begin
            ph <= 2'd0; bitn <= 4'd0;
            if (wr_go) begin st <= XFER; mode <= M_TX; sh <= {wr_data, 1'b1}; end
            else if (cmd_go) begin
              case (cmd_op)
                3'd0: begin st <= GEN_S;  sda_oe <= 1'b0; scl_oe <= 1'b0; end
                3'd1: begin st <= GEN_RS; sda_oe <= 1'b0; scl_oe <= 1'b1; end
                3'd2: begin st <= GEN_P;  sda_oe <= 1'b1; scl_oe <= 1'b1; end
                3'd3: begin st <= XFER; mode <= M_RX;  sh <= '1; end
                3'd4: begin st <= XFER; mode <= M_ACK; sh <= {ack_val, 8'hFF}; end
                default: ;
              endcase
            end
          end
          GEN_S: if (tick) begin
            if (ph == 2'd0) sda_oe <= 1'b1;
            else scl_oe <= 1'b1;
            ph <= ph + 2'd1;
          end
          GEN_RS: if (tick) begin
            if (ph == 2'd0) scl_oe <= 1'b0;
            else if (ph == 2'd1) sda_oe <= 1'b1;
            else scl_oe <= 1'b1;
            ph <= ph + 2'd1;
          end
          GEN_P: if (tick) begin
            if (ph == 2'd0) scl_oe <= 1'b0;
            else sda_oe <= 1'b0;
            ph <= ph + 2'd1;
          end
          XFER: begin
            if (ph == 2'd0 && cnt == DIV_W'(1)) sda_oe <= ~sh[8];
            if (tick && ph == 2'd0) begin scl_oe <= 1'b0; ph <= 2'd1; end
            else if (tick) begin
              sh <= {sh[7:0], sda_s}; bitn <= bitn + 4'd1; scl_oe <= 1'b1; ph <= 2'd0;
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  assert_one_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_seen && stop_seen));
  assert_off_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!start_seen && !stop_seen && !scl_oe && !sda_oe));
  assert_wcol_on_busy_R2: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (busy && (cmd_valid || wr_buf)) |=> wcol);
  assert_loss_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bcol) |-> (!sda_oe && !scl_oe && !busy && !done));
  assert_sda_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == XFER && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));
  assert_done_ends_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: tb/i2c_mm_master_test.sv
module i2c_mm_master_test;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1, irq_en = 1'b1, clr_flags = 1'b0;
  logic [7:0] half_div = 8'd4;
  logic cmd_valid = 1'b0, ack_val = 1'b0, wr_buf = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic ext_scl = 1'b0, ext_sda = 1'b0;
  logic scl_oe, sda_oe, busy, done, irq, ack_rcvd, start_seen, stop_seen, bus_free, wcol, bcol;
  logic [7:0] rx_data;
  wire scl_bus = !(scl_oe | ext_scl);
  wire sda_bus = !(sda_oe | ext_sda);

  int checks = 0, fails = 0;
  logic [8:0] mon = '0;
  int mon_n = 0, hi_chg = 0, rx_drv = 0, rx_idx = 0;
  logic xfer_win = 1'b0, rx_on = 1'b0;
  logic [7:0] rx_pat = 8'h00;
  logic saw_done;

  always #5 clk = ~clk;

  i2c_mm_master #(.DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .irq_en(irq_en), .clr_flags(clr_flags),
    .half_div(half_div), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .ack_val(ack_val),
    .wr_buf(wr_buf), .wr_data(wr_data), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done), .irq(irq),
    .rx_data(rx_data), .ack_rcvd(ack_rcvd), .start_seen(start_seen), .stop_seen(stop_seen),
    .bus_free(bus_free), .wcol(wcol), .bcol(bcol));

  always @(posedge scl_bus) begin mon = {mon[7:0], sda_bus}; mon_n++; end
  always @(sda_bus) if (xfer_win && scl_bus) hi_chg++;
  always @(posedge clk) if (rx_on && scl_bus && sda_oe) rx_drv++;
  always @(negedge scl_bus) if (rx_on) begin
    ext_sda = (rx_idx >= 0) ? !rx_pat[rx_idx] : 1'b0;
    rx_idx--;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk); wr_buf = 1'b1; wr_data = b;
    @(negedge clk); wr_buf = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    saw_done = 1'b0;
    while (busy && n < 3000) begin
      @(negedge clk); n++;
      if (done) saw_done = 1'b1;
    end
  endtask

  task automatic clear();
    @(negedge clk); clr_flags = 1'b1; @(negedge clk); clr_flags = 1'b0;
  endtask

  task automatic t_reset();
    chk("R4", "start_seen after reset", start_seen, 0);
    chk("R4", "stop_seen after reset", stop_seen, 0);
    chk("R5", "bus_free idle", bus_free, 1);
    chk("R1", "busy after reset", busy, 0);
    chk("R11", "lines released", {scl_oe, sda_oe}, 0);
    chk("R2", "wcol after reset", wcol, 0);
  endtask

  task automatic t_bad_op();
    issue(3'd6);
    repeat (20) @(negedge clk);
    chk("R1", "undefined op leaves idle", {busy, scl_oe, sda_oe}, 0);
  endtask

  task automatic t_start_wcol();
    int n0;
    issue(3'd0);
    chk("R1", "busy during START", busy, 1);
    write_byte(8'h5A);
    wait_idle();
    chk("R1", "done on START", saw_done, 1);
    chk("R2", "wcol after early write", wcol, 1);
    chk("R11", "START leaves both low", {scl_oe, sda_oe}, 2'b11);
    chk("R3", "start_seen after own START", {start_seen, stop_seen}, 2'b10);
    chk("R5", "bus_free while busy", bus_free, 0);
    chk("R6", "irq on done", irq, 1);
    n0 = mon_n;
    repeat (60) @(negedge clk);
    chk("R2", "discarded write starts nothing", {busy, 24'(mon_n - n0)}, 0);
    clear();
    chk("R2", "clr_flags clears wcol", {wcol, irq}, 0);
  endtask

  task automatic t_tx(input logic [7:0] b, input logic slave_ack);
    mon_n = 0; hi_chg = 0; ext_sda = slave_ack; xfer_win = 1'b1;
    write_byte(b);
    wait_idle();
    xfer_win = 1'b0; ext_sda = 1'b0;
    chk("R8", "tx bits on wire", {23'(mon_n), mon}, {23'd9, (slave_ack ? 9'h000 : {b, 1'b1})});
    chk("R8", "ack_rcvd", ack_rcvd, !slave_ack);
    chk("R8", "sda stable while scl high", hi_chg, 0);
    chk("R7", "no collision on clean tx", bcol, 0);
    chk("R11", "scl held low after byte", scl_oe, 1);
  endtask

  task automatic t_rx(input logic [7:0] p);
    rx_pat = p; rx_idx = 6; ext_sda = !p[7]; rx_drv = 0; rx_on = 1'b1;
    issue(3'd3);
    wait_idle();
    rx_on = 1'b0; ext_sda = 1'b0;
    chk("R9", "rx_data", rx_data, p);
    chk("R9", "sda released during receive", rx_drv, 0);
    chk("R1", "done on receive", saw_done, 1);
  endtask

  task automatic t_ack(input logic v);
    mon_n = 0; ack_val = v;
    issue(3'd4);
    wait_idle();
    chk("R10", "ack bit on wire", {23'(mon_n), mon[0]}, {23'd1, v});
  endtask

  task automatic t_rstart();
    issue(3'd1);
    wait_idle();
    chk("R11", "repeated START done, lines low", {saw_done, scl_oe, sda_oe}, 3'b111);
    chk("R3", "start_seen after repeated START", {start_seen, stop_seen}, 2'b10);
  endtask

  task automatic t_stretch();
    int n = 0;
    logic seen = 1'b0;
    mon_n = 0; ext_scl = 1'b1;
    write_byte(8'h3C);
    while (n < 150) begin @(negedge clk); n++; if (done) seen = 1'b1; end
    chk("R12", "busy while SCL held low", {busy, seen, 24'(mon_n)}, {1'b1, 1'b0, 24'd0});
    ext_scl = 1'b0;
    wait_idle();
    chk("R12", "byte completes after release", {23'(mon_n), mon}, {23'd9, 9'h079});
  endtask

  task automatic t_stop();
    clear();
    issue(3'd2);
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R11", "STOP releases lines", {saw_done, scl_oe, sda_oe}, 3'b100);
    chk("R3", "stop_seen after STOP", {start_seen, stop_seen}, 2'b01);
    chk("R5", "bus_free after STOP", bus_free, 1);
  endtask

  task automatic t_foreign_stop();
    clear();
    irq_en = 1'b0;
    @(negedge clk); ext_sda = 1'b1; repeat (8) @(negedge clk);
    ext_sda = 1'b0; repeat (8) @(negedge clk);
    chk("R6", "no irq when disabled", irq, 0);
    irq_en = 1'b1;
    ext_sda = 1'b1; repeat (8) @(negedge clk);
    chk("R3", "foreign START seen", {start_seen, stop_seen, bus_free}, 3'b100);
    chk("R6", "no irq on START", irq, 0);
    ext_sda = 1'b0; repeat (8) @(negedge clk);
    chk("R6", "irq on STOP while busy", {irq, stop_seen, bus_free}, 3'b111);
  endtask

  task automatic lose_check(input string what);
    chk("R7", what, {bcol, saw_done, busy, scl_oe, sda_oe}, 5'b10000);
    chk("R7", "irq on loss", irq, 1);
    ext_sda = 1'b0;
    repeat (8) @(negedge clk);
    clear();
  endtask

  task automatic t_lose_start();
    clear();
    ext_sda = 1'b1; repeat (8) @(negedge clk);
    issue(3'd0); wait_idle();
    lose_check("loss in START");
  endtask

  task automatic t_lose_rstart();
    issue(3'd0); wait_idle();
    ext_sda = 1'b1;
    issue(3'd1); wait_idle();
    lose_check("loss in repeated START");
  endtask

  task automatic t_lose_data();
    issue(3'd0); wait_idle();
    ext_sda = 1'b1;
    write_byte(8'hFF); wait_idle();
    lose_check("loss in data bit");
  endtask

  task automatic t_lose_ack();
    issue(3'd0); wait_idle();
    ext_sda = 1'b1; ack_val = 1'b1;
    issue(3'd4); wait_idle();
    lose_check("loss in ack bit");
  endtask

  task automatic t_disable();
    issue(3'd0); wait_idle();
    chk("R3", "start_seen before disable", start_seen, 1);
    @(negedge clk); en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4", "disable clears flags", {start_seen, stop_seen, scl_oe, sda_oe}, 0);
    en = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_bad_op();
    t_start_wcol();
    t_tx(8'hA5, 1'b0);
    t_tx(8'h00, 1'b1);
    t_rx(8'h6B);
    t_ack(1'b0);
    t_ack(1'b1);
    t_rstart();
    t_stretch();
    t_stop();
    t_foreign_stop();
    t_lose_start();
    t_lose_rstart();
    t_lose_data();
    t_lose_ack();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule